// File: doc/BRIEF.md
# Slave Communication Supervisor

This block watches the strobe traffic of a bus slave and reports its health on two status lamps. A watchdog is armed by any strobe on the data port or the parameter port and restarts on every later one. If the strobes stop for long enough, the watchdog fires. A detector counts how long the data strobe pin is held low from outside, so that a long forced low level acts as an external reset. The watchdog, the detector and two master reset commands all feed one registered soft-reset pulse. A copy of that pulse asks the port logic for one forced strobe on both ports. The port logic also uses the soft-reset pulse to release its output drivers.

All timing comes from one millisecond tick divided from the system clock. The watchdog has two states. It starts in `WD_IDLE` and moves to `WD_RUN` on a strobe. A strobe in `WD_RUN` restarts the count. It returns to `WD_IDLE` when it fires, or when a soft reset disarms it (the disarm transition). Firing also sets a sticky "no communication" flag, which only the next strobe or a hard reset clears.

The lamp controller is a state machine with these states: `LS_DARK` (hard reset), `LS_REGULAR`, `LS_NOCOMM`, `LS_ADDR0`, `LS_FAULT` and `LS_EXTRST`. On every clock it moves to the highest-priority state whose condition holds. A free-running blink phase, which a soft reset does not disturb, drives the lamps in the blinking states.

Top module: `slave_supervisor`

## Requirements
- R1: While `rst_hard` is high, both lamp enables, `soft_rst` and `force_strobe` are 0, and every counter and flag is cleared. This includes the "no communication" flag.
- R2: The watchdog stays disarmed after a hard reset until the first strobe (`dstb_evt` or `pstb_evt`). After a strobe with no further strobe, `soft_rst` pulses after WDOG_TICKS ticks. With a tick period of P clocks, the pulse appears between 1+(WDOG_TICKS-1)*P and WDOG_TICKS*P clocks after the strobe is sampled. Each strobe restarts the count.
- R3: `dstb_pin_low` high for LOW_TICKS consecutive ticks produces exactly one `soft_rst` pulse, however long the level stays low. A shorter low phase, or a low phase broken by a high level, produces none.
- R4: A one-cycle `cmd_rst_slave` or `cmd_rst_bcast` produces a `soft_rst` pulse on the next clock edge.
- R5: `soft_rst` and `force_strobe` are one-cycle pulses raised together, and only for the causes in R2 to R4. A soft reset disarms a running watchdog.
- R6: With no fault condition, the green enable is 1 and the red enable is 0.
- R7: While `overload` is high, or while the data strobe pin is still low after the R3 reset, green is 0 and red follows the blink phase.
- R8: While `fault_n` is 0 (and R7 does not apply), green follows the blink phase and red is its inverse.
- R9: When `addr_copy_a` and `addr_copy_b` differ, or are both zero (and R7 and R8 do not apply), red is 1 and green follows the blink phase.
- R10: After the watchdog fires and before the next strobe (and R7 to R9 do not apply), green is 0 and red is 1. A strobe returns the lamps to R6.
- R11: The priority is R7, then R8, then R9, then R10.
- R12: The blink phase toggles every BLINK_TICKS ticks. A soft reset does not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_hard | input | 1 | Hard reset, active high, synchronous |
| dstb_evt | input | 1 | One-cycle pulse: a data-port strobe was issued |
| pstb_evt | input | 1 | One-cycle pulse: a parameter-port strobe was issued |
| dstb_pin_low | input | 1 | Sensed data strobe pin level, 1 = pin low |
| fault_n | input | 1 | Peripheral fault input, active low |
| overload | input | 1 | Field supply overload flag |
| cmd_rst_slave | input | 1 | One-cycle pulse: reset-slave command decoded |
| cmd_rst_bcast | input | 1 | One-cycle pulse: broadcast reset command decoded |
| addr_copy_a | input | ADDR_W | First stored copy of the slave address |
| addr_copy_b | input | ADDR_W | Redundant stored copy of the slave address |
| soft_rst | output | 1 | Soft-reset pulse; also releases the port drivers |
| force_strobe | output | 1 | Request for one forced strobe on both ports |
| led_green_en | output | 1 | Pull-down enable for the green lamp (1 = lit) |
| led_red_en | output | 1 | Pull-down enable for the red lamp (1 = lit) |

## Verification
The soft-reset path is exercised in several ways:
- a lone strobe with no follow-up;
- a strobe train alternating between both ports with gaps shorter than the watchdog limit;
- each of the two commands;
- strobe-pin low phases that are short, broken by a brief high level, or long.

Together these separate firing on silence from restarting on activity, and counting consecutive low ticks from counting total low time. The lamp states are tried with fault conditions stacked from highest priority downward, so that each removal exposes the next level. Blink intervals are measured both undisturbed and across a soft reset, which shows whether the reset touches the blink timer.

// File: rtl/sup_pkg.sv
`timescale 1ns/1ps
package sup_pkg;
    typedef enum logic [2:0] {
        LS_DARK,
        LS_REGULAR,
        LS_NOCOMM,
        LS_ADDR0,
        LS_FAULT,
        LS_EXTRST
    } led_state_t;

    typedef enum logic {
        WD_IDLE,
        WD_RUN
    } wd_state_t;
endpackage

// File: rtl/sup_tick_gen.sv
`timescale 1ns/1ps
module sup_tick_gen #(
    parameter int DIV = 5333
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);

    // R12: the tick never lasts two cycles in a row when DIV > 1
    a_r12_tick_single: assert property (@(posedge clk) disable iff (rst)
        (DIV > 1 && tick) |=> !tick);
endmodule

// File: rtl/sup_strobe_wdog.sv
`timescale 1ns/1ps
module sup_strobe_wdog
    import sup_pkg::*;
#(
    parameter int WDOG_TICKS = 75
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic strobe,
    input  logic disarm,
    output logic fire,
    output logic tripped
);
    localparam int W = (WDOG_TICKS > 1) ? $clog2(WDOG_TICKS) : 1;
    localparam logic [W-1:0] LAST = W'(WDOG_TICKS - 1);

    wd_state_t   state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WD_IDLE;
            cnt_q   <= '0;
            tripped <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (strobe)    tripped <= 1'b0;
            else if (fire) tripped <= 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        fire    = 1'b0;
        unique case (state_q)
            WD_IDLE: begin
                if (strobe) begin
                    state_d = WD_RUN;
                    cnt_d   = '0;
                end
            end
            WD_RUN: begin
                if (strobe) begin
                    cnt_d = '0;
                end else if (disarm) begin
                    state_d = WD_IDLE;
                    cnt_d   = '0;
                end else if (tick) begin
                    if (cnt_q == LAST) begin
                        fire    = 1'b1;
                        state_d = WD_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
        endcase
    end

    // R2: the tick count never passes the limit
    a_r2_cnt_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q < W'(WDOG_TICKS));
    // R10: a firing always leaves the no-communication flag set
    a_r10_trip_set: assert property (@(posedge clk) disable iff (rst)
        fire |=> tripped);
    // R2: a strobe always leaves the watchdog counting from zero
    a_r2_strobe_arms: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (state_q == WD_RUN && cnt_q == '0));
endmodule

// File: rtl/sup_pin_low_det.sv
`timescale 1ns/1ps
module sup_pin_low_det #(
    parameter int LOW_TICKS = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic pin_low,
    output logic fire,
    output logic held
);
    localparam int W = $clog2(LOW_TICKS + 1);
    localparam logic [W-1:0] FULL = W'(LOW_TICKS);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                          cnt_q <= '0;
        else if (!pin_low)                cnt_q <= '0;
        else if (tick && cnt_q != FULL)   cnt_q <= cnt_q + 1'b1;
    end

    assign fire = pin_low && tick && (cnt_q == FULL - 1'b1);
    assign held = pin_low && (cnt_q == FULL);

    // R3: one low phase yields one firing, never two in a row
    a_r3_fire_once: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);
    // R3: once fired, the held flag follows while the pin stays low
    a_r3_held_after: assert property (@(posedge clk) disable iff (rst)
        (fire && pin_low) |=> (held || !pin_low));
endmodule

// File: rtl/sup_led_fsm.sv
`timescale 1ns/1ps
module sup_led_fsm
    import sup_pkg::*;
#(
    parameter int BLINK_TICKS = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic ext_rst,
    input  logic overload,
    input  logic fault_n,
    input  logic addr_zero,
    input  logic no_comm,
    output logic led_green,
    output logic led_red
);
    localparam int BW = (BLINK_TICKS > 1) ? $clog2(BLINK_TICKS) : 1;
    localparam logic [BW-1:0] BLAST = BW'(BLINK_TICKS - 1);

    led_state_t    state_q, state_d;
    logic [BW-1:0] bcnt_q;
    logic          blink_q;

    // blink timer: only a hard reset restarts it
    always_ff @(posedge clk) begin
        if (rst) begin
            bcnt_q  <= '0;
            blink_q <= 1'b0;
        end else if (tick) begin
            if (bcnt_q == BLAST) begin
                bcnt_q  <= '0;
                blink_q <= ~blink_q;
            end else begin
                bcnt_q <= bcnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        if (overload || ext_rst) state_d = LS_EXTRST;
        else if (!fault_n)       state_d = LS_FAULT;
        else if (addr_zero)      state_d = LS_ADDR0;
        else if (no_comm)        state_d = LS_NOCOMM;
        else                     state_d = LS_REGULAR;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= LS_DARK;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            LS_DARK:    begin led_green = 1'b0;     led_red = 1'b0;     end
            LS_REGULAR: begin led_green = 1'b1;     led_red = 1'b0;     end
            LS_NOCOMM:  begin led_green = 1'b0;     led_red = 1'b1;     end
            LS_ADDR0:   begin led_green = blink_q;  led_red = 1'b1;     end
            LS_FAULT:   begin led_green = blink_q;  led_red = ~blink_q; end
            LS_EXTRST:  begin led_green = 1'b0;     led_red = blink_q;  end
            default:    begin led_green = 1'b0;     led_red = 1'b0;     end
        endcase
    end

    // R7: overload darkens green on the following cycle
    a_r7_green_dark: assert property (@(posedge clk) disable iff (rst)
        overload |=> !led_green);
    // R8: fault alone makes the lamps alternate
    a_r8_alternate: assert property (@(posedge clk) disable iff (rst)
        (!overload && !ext_rst && !fault_n) |=> (led_green != led_red));
    // R9: address zero alone keeps red lit
    a_r9_red_on: assert property (@(posedge clk) disable iff (rst)
        (!overload && !ext_rst && fault_n && addr_zero) |=> led_red);
    // R12: the blink phase only moves on a tick
    a_r12_blink_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(blink_q));
endmodule

// File: rtl/slave_supervisor.sv
`timescale 1ns/1ps
module slave_supervisor #(
    parameter int CLK_PER_TICK = 5333,
    parameter int WDOG_TICKS   = 75,
    parameter int LOW_TICKS    = 100,
    parameter int BLINK_TICKS  = 200,
    parameter int ADDR_W       = 6
) (
    input  logic              clk,
    input  logic              rst_hard,
    input  logic              dstb_evt,
    input  logic              pstb_evt,
    input  logic              dstb_pin_low,
    input  logic              fault_n,
    input  logic              overload,
    input  logic              cmd_rst_slave,
    input  logic              cmd_rst_bcast,
    input  logic [ADDR_W-1:0] addr_copy_a,
    input  logic [ADDR_W-1:0] addr_copy_b,
    output logic              soft_rst,
    output logic              force_strobe,
    output logic              led_green_en,
    output logic              led_red_en
);
    logic tick, wd_fire, wd_tripped, low_fire, low_held;
    logic addr_zero, soft_req, rst_d;

    assign addr_zero = (addr_copy_a != addr_copy_b) || (addr_copy_a == '0);
    assign soft_req  = wd_fire | low_fire | cmd_rst_slave | cmd_rst_bcast;

    sup_tick_gen #(.DIV(CLK_PER_TICK)) u_tick (
        .clk(clk), .rst(rst_hard), .tick(tick)
    );

    sup_strobe_wdog #(.WDOG_TICKS(WDOG_TICKS)) u_wdog (
        .clk(clk), .rst(rst_hard), .tick(tick),
        .strobe(dstb_evt | pstb_evt), .disarm(soft_rst),
        .fire(wd_fire), .tripped(wd_tripped)
    );

    sup_pin_low_det #(.LOW_TICKS(LOW_TICKS)) u_lowdet (
        .clk(clk), .rst(rst_hard), .tick(tick), .pin_low(dstb_pin_low),
        .fire(low_fire), .held(low_held)
    );

    sup_led_fsm #(.BLINK_TICKS(BLINK_TICKS)) u_led (
        .clk(clk), .rst(rst_hard), .tick(tick), .ext_rst(low_held),
        .overload(overload), .fault_n(fault_n), .addr_zero(addr_zero),
        .no_comm(wd_tripped), .led_green(led_green_en), .led_red(led_red_en)
    );

    always_ff @(posedge clk) begin
        if (rst_hard) begin
            soft_rst     <= 1'b0;
            force_strobe <= 1'b0;
        end else begin
            soft_rst     <= soft_req;
            force_strobe <= soft_req;
        end
    end

    // R1: one cycle into a hard reset everything visible is quiet
    always_ff @(posedge clk) begin
        rst_d <= rst_hard;
        if (rst_d)
            a_r1_dark: assert (!led_green_en && !led_red_en && !soft_rst && !force_strobe);
    end

    // R4: a reset command is answered on the next edge
    a_r4_cmd_soft: assert property (@(posedge clk) disable iff (rst_hard)
        (cmd_rst_slave || cmd_rst_bcast) |=> (soft_rst && force_strobe));
    // R5: no soft reset appears without a cause one cycle earlier
    a_r5_cause: assert property (@(posedge clk) disable iff (rst_hard)
        !(wd_fire || low_fire || cmd_rst_slave || cmd_rst_bcast) |=> !soft_rst);
endmodule

// File: tb/slave_supervisor_tb_top.sv
`timescale 1ns/1ps
module slave_supervisor_tb_top;
    localparam int P  = 4;
    localparam int WD = 6;
    localparam int LO = 8;
    localparam int BL = 5;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_hard = 1'b1;
    logic dstb_evt = 0, pstb_evt = 0, dstb_pin_low = 0, fault_n = 1, overload = 0;
    logic cmd_rst_slave = 0, cmd_rst_bcast = 0;
    logic [5:0] addr_copy_a = 6'd5, addr_copy_b = 6'd5;
    logic soft_rst, force_strobe, led_green_en, led_red_en;

    slave_supervisor #(.CLK_PER_TICK(P), .WDOG_TICKS(WD), .LOW_TICKS(LO),
                       .BLINK_TICKS(BL), .ADDR_W(6)) dut_i (
        .clk(clk), .rst_hard(rst_hard), .dstb_evt(dstb_evt), .pstb_evt(pstb_evt),
        .dstb_pin_low(dstb_pin_low), .fault_n(fault_n), .overload(overload),
        .cmd_rst_slave(cmd_rst_slave), .cmd_rst_bcast(cmd_rst_bcast),
        .addr_copy_a(addr_copy_a), .addr_copy_b(addr_copy_b),
        .soft_rst(soft_rst), .force_strobe(force_strobe),
        .led_green_en(led_green_en), .led_red_en(led_red_en)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int nchk = 0, nfail = 0, n_soft = 0;

    task automatic check(bit ok, string tag, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    typedef struct { int lo; int hi; string tag; } exp_t;
    exp_t sb_q[$];
    exp_t mon_e;

    task automatic expect_rst(int lo, int hi, string tag);
        exp_t e;
        e.lo = lo; e.hi = hi; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // monitor: pops expected soft resets as they appear
    always @(negedge clk) begin
        if (!rst_hard) begin
            if (sb_q.size() > 0 && cyc > sb_q[0].hi) begin
                mon_e = sb_q.pop_front();
                check(1'b0, mon_e.tag, "soft reset missing by cycle", cyc, mon_e.hi);
            end
            if (soft_rst) begin
                n_soft++;
                if (sb_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected soft reset at cycle", cyc, -1);
                end else begin
                    mon_e = sb_q.pop_front();
                    check(cyc >= mon_e.lo && cyc <= mon_e.hi, mon_e.tag,
                          "soft reset cycle", cyc, mon_e.lo);
                end
                check(force_strobe == 1'b1, "R5", "force_strobe with soft_rst", int'(force_strobe), 1);
            end
        end
    end

    task automatic cyc_wait(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe_d();
        dstb_evt = 1'b1; @(negedge clk); dstb_evt = 1'b0;
    endtask
    task automatic strobe_p();
        pstb_evt = 1'b1; @(negedge clk); pstb_evt = 1'b0;
    endtask
    task automatic cmd_slave();
        cmd_rst_slave = 1'b1; @(negedge clk); cmd_rst_slave = 1'b0;
    endtask
    task automatic cmd_bcast();
        cmd_rst_bcast = 1'b1; @(negedge clk); cmd_rst_bcast = 1'b0;
    endtask

    task automatic observe(int n, output int g_tog, output int r_tog,
                           output int g_hi, output int r_hi, output int neq);
        logic pg, pr;
        pg = led_green_en; pr = led_red_en;
        g_tog = 0; r_tog = 0; g_hi = 0; r_hi = 0; neq = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (led_green_en != pg) g_tog++;
            if (led_red_en != pr)   r_tog++;
            if (led_green_en) g_hi++;
            if (led_red_en)   r_hi++;
            if (led_green_en != led_red_en) neq++;
            pg = led_green_en; pr = led_red_en;
        end
    endtask

    task automatic wait_g_toggle(output int t);
        logic p;
        bit done;
        p = led_green_en; t = -1; done = 0;
        for (int i = 0; i < 200; i++) begin
            if (!done) begin
                @(negedge clk);
                if (led_green_en != p) begin t = cyc; done = 1; end
            end
        end
    endtask

    task automatic chk_leds(string tag, logic g, logic r);
        check(led_green_en == g, tag, "green enable", int'(led_green_en), int'(g));
        check(led_red_en == r, tag, "red enable", int'(led_red_en), int'(r));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", cyc, 0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        int gt, rt, gh, rh, ne, t0, t1, ns;
        cyc_wait(5);
        // R1: quiet during hard reset
        chk_leds("R1", 1'b0, 1'b0);
        check(soft_rst == 1'b0, "R1", "soft_rst in reset", int'(soft_rst), 0);
        rst_hard = 1'b0;
        cyc_wait(3);
        chk_leds("R6", 1'b1, 1'b0);
        // R2: no strobe yet, so no watchdog reset
        ns = n_soft;
        cyc_wait(60);
        check(n_soft == ns, "R2", "pulses before first strobe", n_soft - ns, 0);

        // R2: lone strobe leads to a watchdog reset
        expect_rst(cyc + 2 + (WD - 1) * P, cyc + 1 + WD * P, "R2");
        strobe_d();
        cyc_wait(40);
        chk_leds("R10", 1'b0, 1'b1);

        // R2: strobe train on both ports keeps it quiet
        ns = n_soft;
        for (int i = 0; i < 8; i++) begin
            if (i % 2 == 0) strobe_d(); else strobe_p();
            cyc_wait(14);
        end
        check(n_soft == ns, "R2", "pulses during strobe train", n_soft - ns, 0);
        chk_leds("R10", 1'b1, 1'b0);

        // R4 and R5: command resets and disarms the watchdog
        ns = n_soft;
        expect_rst(cyc + 1, cyc + 1, "R4");
        cmd_slave();
        cyc_wait(60);
        check(n_soft == ns + 1, "R5", "pulses after disarming command", n_soft - ns, 1);
        expect_rst(cyc + 1, cyc + 1, "R4");
        cmd_bcast();
        cyc_wait(5);

        // R3: short and broken low phases do nothing
        ns = n_soft;
        dstb_pin_low = 1'b1; cyc_wait(20);
        dstb_pin_low = 1'b0; cyc_wait(2);
        dstb_pin_low = 1'b1; cyc_wait(20);
        dstb_pin_low = 1'b0; cyc_wait(10);
        check(n_soft == ns, "R3", "pulses from short low phases", n_soft - ns, 0);

        // R3 and R7: long low phase gives one reset and the reset lamp pattern
        ns = n_soft;
        expect_rst(cyc + 1 + (LO - 1) * P, cyc + LO * P, "R3");
        dstb_pin_low = 1'b1;
        cyc_wait(34);
        observe(50, gt, rt, gh, rh, ne);
        check(gh == 0, "R7", "green lit cycles while pin held", gh, 0);
        check(rt >= 2, "R7", "red toggles while pin held", rt, 2);
        dstb_pin_low = 1'b0;
        cyc_wait(3);
        check(n_soft == ns + 1, "R3", "pulses from one long low phase", n_soft - ns, 1);
        chk_leds("R6", 1'b1, 1'b0);

        // R11 and R7: overload wins over fault and bad address
        overload = 1'b1; fault_n = 1'b0; addr_copy_b = 6'd9;
        cyc_wait(3);
        observe(50, gt, rt, gh, rh, ne);
        check(gh == 0, "R11", "green lit cycles under overload", gh, 0);
        check(rt >= 2, "R7", "red toggles under overload", rt, 2);

        // R8 and R11: fault wins over bad address
        overload = 1'b0;
        cyc_wait(3);
        observe(50, gt, rt, gh, rh, ne);
        check(ne == 50, "R8", "cycles with lamps opposite", ne, 50);
        check(gt >= 2, "R11", "green toggles under fault", gt, 2);

        // R9: copies differ
        fault_n = 1'b1;
        cyc_wait(3);
        observe(50, gt, rt, gh, rh, ne);
        check(rh == 50, "R9", "red lit cycles on copy mismatch", rh, 50);
        check(gt >= 2, "R9", "green toggles on copy mismatch", gt, 2);

        // R12: blink interval, undisturbed and across a soft reset
        wait_g_toggle(t0);
        wait_g_toggle(t1);
        check(t1 - t0 == BL * P, "R12", "blink half period", t1 - t0, BL * P);
        wait_g_toggle(t0);
        cyc_wait(5);
        expect_rst(cyc + 1, cyc + 1, "R4");
        cmd_slave();
        wait_g_toggle(t1);
        check(t1 - t0 == BL * P, "R12", "blink half period across soft reset", t1 - t0, BL * P);

        // R9: both copies zero
        addr_copy_a = 6'd0; addr_copy_b = 6'd0;
        cyc_wait(3);
        observe(30, gt, rt, gh, rh, ne);
        check(rh == 30, "R9", "red lit cycles on zero address", rh, 30);
        addr_copy_a = 6'd5; addr_copy_b = 6'd5;
        cyc_wait(3);
        chk_leds("R6", 1'b1, 1'b0);

        // R11: address zero outranks lost communication
        addr_copy_a = 6'd0; addr_copy_b = 6'd0;
        expect_rst(cyc + 2 + (WD - 1) * P, cyc + 1 + WD * P, "R2");
        strobe_d();
        cyc_wait(40);
        observe(30, gt, rt, gh, rh, ne);
        check(gt >= 1 && rh == 30, "R11", "green toggles with zero address and no comm", gt, 1);
        addr_copy_a = 6'd5; addr_copy_b = 6'd5;
        cyc_wait(3);
        chk_leds("R10", 1'b0, 1'b1);

        // R1: hard reset darkens lamps and clears the no-communication flag
        rst_hard = 1'b1;
        cyc_wait(2);
        chk_leds("R1", 1'b0, 1'b0);
        rst_hard = 1'b0;
        cyc_wait(3);
        chk_leds("R1", 1'b1, 1'b0);

        cyc_wait(5);
        check(sb_q.size() == 0, "R5", "expected resets left over", sb_q.size(), 0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule